// File: doc/BRIEF.md
# DAC Serial Register-Access Engine

This block lets a host processor reach the internal registers of an external serial DAC. It also switches the serial link into a continuous sample-streaming mode. The host side is a small 32-bit register bus with a write strobe, a word address and combinational read data. The device side is a serial clock, an active-low chip select, a serial data output and a serial data input.

The host loads a payload and a mode word. It then writes the control register with an 8-bit device address and a rising trigger bit, and polls the busy status until the frame is done. For a read, the address byte carries bit 7 set. The bits returned on the serial input during the data phase land in a readback register. If the stream bit is written together with the rising trigger, the engine sends the address once. It then sends 16-bit samples back to back, taken from a sample input port, until the host clears both bits.

The engine has four states. ST_IDLE waits for a start. ST_FRAME shifts one register frame. ST_STREAM shifts the address and then the samples. ST_TAIL holds chip select low for the release delay. The transitions are:
- ST_IDLE to ST_FRAME on a start without the stream bit.
- ST_IDLE to ST_STREAM on a start with the stream bit.
- ST_FRAME to ST_TAIL after the last bit.
- ST_STREAM to ST_TAIL at a sample boundary when the trigger and stream bits are both clear.
- ST_TAIL to ST_IDLE after the release delay.

Top module: `dac_regbus_engine`

## Requirements
- R1: The register word addresses are 0 (mode), 1 (write payload), 2 (readback, read-only), 3 (status, read-only) and 4 (control). Writing mode, payload or control stores the full 32-bit value, and reading it returns that value. In the control word, bits 31:24 are the device address, bit 0 is the trigger, bit 1 is stream enable and bit 2 is the synced flag. The synced flag is stored only, and writing control without a rising trigger sends no frame.
- R2: A frame starts only when a control write takes bit 0 from 0 to 1 while the engine is idle. Leaving the bit high after completion starts nothing. A 0-to-1 edge written while busy is ignored.
- R3: Status bit 4 (busy) reads 1 in the cycle right after the accepted trigger write. It stays 1 until chip select has been released, then reads 0.
- R4: A frame drives chip select low and sends the 8-bit address MSB first, then the data phase MSB first. With mode bit 14 set, the data phase is 8 bits taken from payload bits 23:16. With mode bit 14 clear, it is 16 bits taken from payload bits 23:8.
- R5: With mode bit 16 set (SDR), each bit lasts two clock cycles: serial clock low, then high. With mode bit 16 clear (DDR), each bit lasts one cycle and the serial clock toggles between bits, so the bits are presented on both edges.
- R6: After the last bit, chip select stays low with the serial clock low for one serial-clock period (2 clock cycles). Chip select is then released.
- R7: When address bit 7 is set, the serial input is sampled at the end of each data-phase bit. At the end of the frame, the 8 or 16 bits go into the low bits of the readback register with all upper bits zero. A frame without address bit 7 leaves the readback register unchanged.
- R8: A rising trigger written together with bit 1 sends the address once, followed by an unbroken series of 16-bit samples with chip select held low. The sample port is read on each cycle in which smp_take pulses. When control bits 0 and 1 are both clear at the end of a sample, the engine goes to the release delay.
- R9: After reset, all readable registers are zero, chip select is high, and the serial clock and serial output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| smp_data | input | 16 | Next stream sample |
| smp_take | output | 1 | Pulses when smp_data is loaded |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_sdo | output | 1 | Serial data to the DAC |
| dac_sdi | input | 1 | Serial data from the DAC |

## Verification
The bench holds the trigger high after a frame and also raises it a second time while busy. An engine that works on the level, or that accepts edges during a frame, would send an extra frame that the bench's serial-side capture counts. It reads busy in the very first cycle after the trigger write, so a registered edge detector that lags by one cycle is caught. It performs an 8-bit read driven with ones above bit 7, then a write, and checks that the readback stays zero-extended and unchanged. A design that captured too many bits or overwrote the readback on writes would fail this. Streams in both SDR and DDR are stopped in the middle of a sample. The bench checks that chip select stays low across sample boundaries, that every sample appears in order, and that the number of bits matches the number of smp_take pulses.

// File: rtl/dac_regbus_pkg.sv
`timescale 1ns/1ps
package dac_regbus_pkg;
    localparam int REG_W  = 32;
    localparam int BADR_W = 3;

    localparam logic [BADR_W-1:0] RA_MODE  = 3'd0;
    localparam logic [BADR_W-1:0] RA_WDATA = 3'd1;
    localparam logic [BADR_W-1:0] RA_RDBK  = 3'd2;
    localparam logic [BADR_W-1:0] RA_STAT  = 3'd3;
    localparam logic [BADR_W-1:0] RA_CTRL  = 3'd4;

    localparam int CTL_TRIG  = 0;
    localparam int CTL_STRM  = 1;
    localparam int MODE_SZ8  = 14;
    localparam int MODE_SDR  = 16;
    localparam int STAT_BUSY = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_STREAM,
        ST_TAIL
    } eng_state_t;
endpackage

// File: rtl/dac_regbus_regs.sv
`timescale 1ns/1ps
module dac_regbus_regs
    import dac_regbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BADR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              busy,
    input  logic [REG_W-1:0]  rdback,
    output logic [REG_W-1:0]  mode_q,
    output logic [REG_W-1:0]  wdat_q,
    output logic [REG_W-1:0]  ctrl_q,
    output logic              ctrl_wr,
    output logic [REG_W-1:0]  bus_rdata
);
    assign ctrl_wr = bus_we && (bus_addr == RA_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            wdat_q <= '0;
            ctrl_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == RA_MODE)  mode_q <= bus_wdata;
            if (bus_addr == RA_WDATA) wdat_q <= bus_wdata;
            if (bus_addr == RA_CTRL)  ctrl_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_MODE:  bus_rdata = mode_q;
            RA_WDATA: bus_rdata = wdat_q;
            RA_RDBK:  bus_rdata = rdback;
            RA_STAT:  bus_rdata[STAT_BUSY] = busy;
            RA_CTRL:  bus_rdata = ctrl_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dac_regbus_fsm.sv
`timescale 1ns/1ps
module dac_regbus_fsm
    import dac_regbus_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SMP_W       = 16,
    parameter int TAIL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sdr,
    input  logic              mode_sz8,
    input  logic [SMP_W-1:0]  pay_wide,
    input  logic [1:0]        ctl_bits,
    input  logic              ctrl_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_trig,
    input  logic              wr_strm,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic              dac_sdi,
    output logic              busy,
    output logic [REG_W-1:0]  rdback,
    output logic              smp_take,
    output logic              dac_sclk,
    output logic              dac_cs_n,
    output logic              dac_sdo
);
    localparam int HALF_W  = SMP_W / 2;
    localparam int FRAME_W = ADDR_W + SMP_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int TAIL_W  = $clog2(TAIL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(ADDR_W + HALF_W - 1);
    localparam logic [CNT_W-1:0] DATA_FIRST  = CNT_W'(ADDR_W);

    eng_state_t           state_q, state_d;
    logic [FRAME_W-1:0]   sh_q;
    logic [CNT_W-1:0]     bidx_q;
    logic                 ph_q, ddr_q, sz8_q, rd_q;
    logic [SMP_W-1:0]     rx_q;
    logic [TAIL_W-1:0]    tail_q;

    logic start, bit_end, last_bit, keep_strm, reload;
    logic [SMP_W-1:0] rx_next;

    assign start     = ctrl_wr && wr_trig && !ctl_bits[CTL_TRIG] && (state_q == ST_IDLE);
    assign bit_end   = ddr_q | ph_q;
    assign last_bit  = (bidx_q == (sz8_q ? LAST_NARROW : LAST_WIDE));
    assign keep_strm = ctl_bits[CTL_TRIG] | ctl_bits[CTL_STRM];
    assign reload    = (state_q == ST_STREAM) && bit_end && (bidx_q == LAST_WIDE) && keep_strm;
    assign rx_next   = {rx_q[SMP_W-2:0], dac_sdi};
    assign smp_take  = (start && wr_strm) || reload;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = wr_strm ? ST_STREAM : ST_FRAME;
            ST_FRAME:  if (bit_end && last_bit) state_d = ST_TAIL;
            ST_STREAM: if (bit_end && (bidx_q == LAST_WIDE) && !keep_strm) state_d = ST_TAIL;
            ST_TAIL:   if (tail_q == TAIL_W'(TAIL_CYCLES - 1)) state_d = ST_IDLE;
        endcase
    end

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            bidx_q  <= '0;
            ph_q    <= 1'b0;
            ddr_q   <= 1'b0;
            sz8_q   <= 1'b0;
            rd_q    <= 1'b0;
            rx_q    <= '0;
            tail_q  <= '0;
            rdback  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ddr_q  <= !mode_sdr;
                        sz8_q  <= mode_sz8 && !wr_strm;
                        rd_q   <= wr_addr[ADDR_W-1] && !wr_strm;
                        bidx_q <= '0;
                        ph_q   <= 1'b0;
                        rx_q   <= '0;
                        if (wr_strm)
                            sh_q <= {wr_addr, smp_data};
                        else if (mode_sz8)
                            sh_q <= {wr_addr, pay_wide[SMP_W-1 -: HALF_W], {HALF_W{1'b0}}};
                        else
                            sh_q <= {wr_addr, pay_wide};
                    end
                end
                ST_FRAME, ST_STREAM: begin
                    tail_q <= '0;
                    if (!ddr_q) ph_q <= ~ph_q;
                    if (bit_end) begin
                        sh_q   <= sh_q << 1;
                        bidx_q <= bidx_q + 1'b1;
                        if (rd_q && (bidx_q >= DATA_FIRST)) rx_q <= rx_next;
                        if ((state_q == ST_FRAME) && last_bit && rd_q)
                            rdback <= sz8_q ? REG_W'(rx_next[HALF_W-1:0]) : REG_W'(rx_next);
                        if (reload) begin
                            sh_q   <= {smp_data, {ADDR_W{1'b0}}};
                            bidx_q <= DATA_FIRST;
                        end
                    end
                end
                ST_TAIL: tail_q <= tail_q + 1'b1;
            endcase
        end
    end

    // output decode
    always_comb begin
        busy     = (state_q != ST_IDLE);
        dac_cs_n = 1'b1;
        dac_sclk = 1'b0;
        dac_sdo  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FRAME, ST_STREAM: begin
                dac_cs_n = 1'b0;
                dac_sdo  = sh_q[FRAME_W-1];
                dac_sclk = ddr_q ? bidx_q[0] : ph_q;
            end
            ST_TAIL: dac_cs_n = 1'b0;
        endcase
    end
endmodule

// File: rtl/dac_regbus_engine.sv
`timescale 1ns/1ps
module dac_regbus_engine
    import dac_regbus_pkg::*;
#(
    parameter int TAIL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       smp_data,
    output logic              smp_take,
    output logic              dac_sclk,
    output logic              dac_cs_n,
    output logic              dac_sdo,
    input  logic              dac_sdi
);
    logic [REG_W-1:0] mode_q, wdat_q, ctrl_q, rdback;
    logic             ctrl_wr, busy;

    dac_regbus_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .rdback    (rdback),
        .mode_q    (mode_q),
        .wdat_q    (wdat_q),
        .ctrl_q    (ctrl_q),
        .ctrl_wr   (ctrl_wr),
        .bus_rdata (bus_rdata)
    );

    dac_regbus_fsm #(
        .ADDR_W      (8),
        .SMP_W       (16),
        .TAIL_CYCLES (TAIL_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sdr (mode_q[MODE_SDR]),
        .mode_sz8 (mode_q[MODE_SZ8]),
        .pay_wide (wdat_q[23:8]),
        .ctl_bits (ctrl_q[1:0]),
        .ctrl_wr  (ctrl_wr),
        .wr_addr  (bus_wdata[31:24]),
        .wr_trig  (bus_wdata[CTL_TRIG]),
        .wr_strm  (bus_wdata[CTL_STRM]),
        .smp_data (smp_data),
        .dac_sdi  (dac_sdi),
        .busy     (busy),
        .rdback   (rdback),
        .smp_take (smp_take),
        .dac_sclk (dac_sclk),
        .dac_cs_n (dac_cs_n),
        .dac_sdo  (dac_sdo)
    );
endmodule

// File: rtl/dac_regbus_chk.sv
`timescale 1ns/1ps
module dac_regbus_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        trig_q,
    input logic        ctrl_wr,
    input logic        wr_trig,
    input logic [15:0] rb_upper,
    input logic        smp_take,
    input logic        cs_n,
    input logic        sclk
);
    assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_q && !ctrl_wr) |=> !busy);

    assert_busy_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_trig && !trig_q && !busy) |=> busy);

    assert_idle_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    assert_rdback_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rb_upper == 16'h0000);

    assert_take_streams_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_take |=> (busy && !cs_n));
endmodule

bind dac_regbus_engine dac_regbus_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .trig_q   (ctrl_q[0]),
    .ctrl_wr  (ctrl_wr),
    .wr_trig  (bus_wdata[0]),
    .rb_upper (rdback[31:16]),
    .smp_take (smp_take),
    .cs_n     (dac_cs_n),
    .sclk     (dac_sclk)
);

// File: tb/tb_dac_regbus_engine.sv
`timescale 1ns/1ps
module tb_dac_regbus_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] smp_data = 16'hA001;
    logic        smp_take;
    logic        dac_sclk, dac_cs_n, dac_sdo;
    logic        dac_sdi = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dac_regbus_engine dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_data(smp_data),
        .smp_take(smp_take), .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n),
        .dac_sdo(dac_sdo), .dac_sdi(dac_sdi)
    );

    always #10 clk = ~clk;

    // serial-side device model
    logic        cap_bits [0:1023];
    int          cap_n = 0;
    int          cs_low = 0;
    int          take_n = 0;
    bit          mdl_ddr = 1'b0;
    int          mdl_nd = 16;
    logic [15:0] mdl_resp = '0;
    logic        prev_sclk = 1'b0, prev_cs = 1'b1, prev_sdo = 1'b0;

    always @(negedge clk) begin
        if (!dac_cs_n) cs_low++;
        if (!mdl_ddr) begin
            if (!dac_cs_n && dac_sclk && !prev_sclk && cap_n < 1024) begin
                cap_bits[cap_n] = dac_sdo;
                if (cap_n >= 8 && (cap_n - 8) < mdl_nd)
                    dac_sdi = mdl_resp[mdl_nd - 1 - (cap_n - 8)];
                cap_n++;
            end
        end else if (!prev_cs && (dac_sclk != prev_sclk) && cap_n < 1024) begin
            cap_bits[cap_n] = prev_sdo;
            cap_n++;
        end
        prev_sclk = dac_sclk;
        prev_cs   = dac_cs_n;
        prev_sdo  = dac_sdo;
    end

    always @(posedge clk) begin
        if (smp_take) begin
            smp_data <= smp_data + 16'h1357;
            take_n++;
        end
    end

    function automatic logic [31:0] get_bits(input int start, input int n);
        logic [31:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[30:0], cap_bits[start + i]};
        return v;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            peek(3'd3, s);
            if (!s[4]) break;
        end
    endtask

    task automatic clear_cap();
        cap_n = 0; cs_low = 0; take_n = 0;
    endtask

    // {ddr, sz8, addr, payload, response}
    localparam logic [57:0] VECS [0:6] = '{
        {1'b0, 1'b0, 8'h12, 32'h00ABCD00, 16'h0000},
        {1'b0, 1'b1, 8'h05, 32'h005A0000, 16'h0000},
        {1'b0, 1'b0, 8'h93, 32'h00000000, 16'hBEEF},
        {1'b0, 1'b1, 8'h81, 32'h00000000, 16'hFFC3},
        {1'b1, 1'b0, 8'h40, 32'h00123400, 16'h0000},
        {1'b1, 1'b1, 8'h7F, 32'hFF990000, 16'h0000},
        {1'b0, 1'b0, 8'h22, 32'h00F00F00, 16'h0000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_rb;
        repeat (3) @(negedge clk);
        // R9 reset state
        for (int a = 0; a < 5; a++) begin
            peek(3'(a), v);
            chk("R9", "register after reset", v, 32'h0);
        end
        chk("R9", "cs_n/sclk/sdo after reset", {29'h0, dac_cs_n, dac_sclk, dac_sdo}, 32'h4);
        rst_n = 1'b1;

        // R1 storage and readback, synced flag alone sends nothing
        clear_cap();
        wr(3'd0, 32'h0001_4000);
        wr(3'd1, 32'hDEAD_BEEF);
        wr(3'd4, 32'hA500_0004);
        repeat (10) @(negedge clk);
        peek(3'd0, v); chk("R1", "mode readback", v, 32'h0001_4000);
        peek(3'd1, v); chk("R1", "payload readback", v, 32'hDEAD_BEEF);
        peek(3'd4, v); chk("R1", "control readback", v, 32'hA500_0004);
        chk("R1", "no frame without trigger", cap_n, 0);

        // table walk: R3 R4 R5 R6 R7
        exp_rb = 32'h0;
        wr(3'd4, 32'h0);
        for (int k = 0; k < 7; k++) begin
            logic        ddr, sz8;
            logic [7:0]  adr;
            logic [31:0] pay;
            logic [15:0] rsp;
            logic [31:0] exp_frame;
            int          nd;
            {ddr, sz8, adr, pay, rsp} = VECS[k];
            nd = sz8 ? 8 : 16;
            exp_frame = sz8 ? {16'h0, adr, pay[23:16]} : {8'h0, adr, pay[23:8]};
            mdl_ddr = ddr; mdl_nd = nd; mdl_resp = rsp;
            wr(3'd0, {15'h0, !ddr, 1'b0, sz8, 14'h0});
            wr(3'd1, pay);
            clear_cap();
            wr(3'd4, {adr, 21'h0, 3'b001});
            peek(3'd3, v);
            chk("R3", "busy right after trigger", {31'h0, v[4]}, 32'h1);
            wait_idle();
            wr(3'd4, {adr, 24'h0});
            chk("R4", "bit count", cap_n, 8 + nd);
            chk("R4", "frame bits", get_bits(0, 8 + nd), exp_frame);
            chk(ddr ? "R5" : "R6", "cs low cycles", cs_low, ddr ? (8 + nd + 2) : (2 * (8 + nd) + 2));
            if (adr[7]) exp_rb = sz8 ? {24'h0, rsp[7:0]} : {16'h0, rsp};
            peek(3'd2, v);
            chk("R7", "readback", v, exp_rb);
        end

        // R2: held trigger does not restart
        mdl_ddr = 1'b0;
        wr(3'd0, 32'h0001_0000);
        clear_cap();
        wr(3'd4, 32'h3300_0001);
        wait_idle();
        repeat (30) @(negedge clk);
        chk("R2", "held trigger frames", cap_n, 24);
        // R2: edge while busy ignored
        wr(3'd4, 32'h3300_0000);
        clear_cap();
        wr(3'd4, 32'h3300_0001);
        wr(3'd4, 32'h3300_0000);
        wr(3'd4, 32'h3300_0001);
        peek(3'd3, v);
        chk("R2", "still busy in first frame", {31'h0, v[4]}, 32'h1);
        wait_idle();
        repeat (30) @(negedge clk);
        chk("R2", "edge during busy frames", cap_n, 24);
        wr(3'd4, 32'h0);

        // R8 streaming, SDR then DDR
        for (int m = 0; m < 2; m++) begin
            int bad;
            logic [15:0] s0;
            mdl_ddr = (m == 1);
            wr(3'd0, m == 1 ? 32'h0 : 32'h0001_0000);
            clear_cap();
            s0 = smp_data;
            wr(3'd4, 32'h2C00_0003);
            peek(3'd3, v);
            chk("R8", "busy in stream", {31'h0, v[4]}, 32'h1);
            repeat (m == 1 ? 45 : 75) @(negedge clk);
            wr(3'd4, 32'h2C00_0000);
            wait_idle();
            repeat (4) @(negedge clk);
            chk("R8", "bits vs samples", cap_n, 8 + 16 * take_n);
            chk("R8", "several samples", {31'h0, take_n >= 2}, 32'h1);
            chk("R8", "stream address", get_bits(0, 8), 32'h2C);
            bad = 0;
            for (int j = 0; j < take_n; j++)
                if (get_bits(8 + 16 * j, 16) != 32'(s0 + 16'(j) * 16'h1357)) bad++;
            chk("R8", "sample contents", bad, 0);
            chk(m == 1 ? "R5" : "R8", "unbroken cs low", cs_low, m == 1 ? cap_n + 2 : 2 * cap_n + 2);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule